// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block is a bus master that carries single-byte reads and writes from a CPU-side request port to an external memory bus with a 16-bit address. The bus has three parts. The low address byte and the data byte share one 8-bit port. The high address byte has its own 8-bit output. An address-latch strobe and active-low read and write strobes control the cycle. The external side latches the low address byte on the falling edge of the latch strobe. After that edge, the shared port carries data.

The block runs on a clock at twice the CPU rate. One internal cycle is therefore half a CPU clock, and a phase counter places every bus edge on a whole or half CPU-clock boundary. A two-bit wait-state mode is sampled with each request. The mode sets how long the read or write strobe stays low. In the slowest mode the mode also lengthens how long write data is held after the write strobe rises. The shared port is modelled as separate out, output-enable and in signals, so that the tristate buffer sits at the pad.

In the requirements, internal cycle n means the n-th cycle after the clock edge that accepts a request. Cycle 0 is the first cycle after that edge. S and H are counted in CPU clocks.

Top module: `xmem_mux_ctrl`

## Requirements
- R1: While reset is held, the bus is idle: `bus_ale` is 0, `bus_rd_n` and `bus_wr_n` are 1, `bus_ad_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 when the controller is idle or is in the final cycle of an access, and 0 otherwise. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `bus_ahi` shows the accepted address bits 15:8 from cycle 0 until the next acceptance.
- R3: `bus_ale` is 1 in cycles 1 and 2 only. In cycles 0 to 2 the shared port is driven with address bits 7:0.
- R4: In cycle 3 `bus_ale` is low. A read still drives address bits 7:0 in this cycle, and a write drives its write data instead.
- R5: The access strobe is low in cycles 4 to 3+2S. The access strobe is `bus_rd_n` for a read and `bus_wr_n` for a write. S is 1, 2, 3 and 3 for modes 0, 1, 2 and 3. The other strobe stays high.
- R6: For a read, `bus_ad_oe` is 0 from cycle 4 to the end of the access. `rdata` holds the value that `bus_ad_in` had in cycle 3+2S, which is the last cycle with the read strobe low.
- R7: For a write, the write data stays driven from cycle 3 until 2H cycles after `bus_wr_n` rises, and is then released. H is 2 in mode 3 and 1 in the other modes.
- R8: An access lasts L = 4+2S+2H internal cycles, which is 8, 10, 12 or 14. `done` is 1 in cycle L-1 only, which is a single-cycle pulse.
- R9: Address, write flag, write data and mode are captured at acceptance. Changes on the request inputs during an access have no effect on that access.
- R10: A request that is valid in the final cycle of an access is accepted there. The next access then starts with no idle cycle, and its latch pulse appears in its own cycles 1 and 2. With no pending request, the latch strobe stays low and the shared port is released.
- R11: `bus_rd_n` and `bus_wr_n` are never low together, and neither is low while `bus_ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the CPU rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Wait-state mode 0 to 3 |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle pulse in the last cycle of an access |
| rdata | output | 8 | Captured read data |
| bus_ale | output | 1 | Address-latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ahi | output | 8 | High address byte |
| bus_ad_out | output | 8 | Shared port, outgoing value |
| bus_ad_oe | output | 1 | Shared port output enable |
| bus_ad_in | input | 8 | Shared port, incoming value |

## Verification
Two events can fall in the same cycle: the completion of one access (its `done` pulse and its last write-hold or read cycle) and the acceptance of the next request. The bench provokes this by raising `req_valid` in the final cycle of an access, across pairs of modes and mixed read/write order. It then requires the next access to begin on the following edge. In that next access the latch pulse must appear in cycles 1 and 2, the new high address byte must be present, and no idle cycle may come in between. The previous access must still complete with correct read data or correct write hold.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

  typedef enum logic [1:0] {
    WS_NONE     = 2'd0,
    WS_ONE      = 2'd1,
    WS_TWO      = 2'd2,
    WS_TWO_HOLD = 2'd3
  } ws_mode_e;

  // phase counter width; longest access is 14 half-clock phases
  localparam int unsigned PH_W = 4;

  localparam logic [PH_W-1:0] PH_ONE          = PH_W'(1);
  localparam logic [PH_W-1:0] PH_ALE_FIRST    = PH_W'(1);
  localparam logic [PH_W-1:0] PH_ALE_LAST     = PH_W'(2);
  localparam logic [PH_W-1:0] PH_ADDR_TAIL    = PH_W'(3);
  localparam logic [PH_W-1:0] PH_STROBE_START = PH_W'(4);

  // strobe-low length in half-clock phases
  function automatic logic [PH_W-1:0] strobe_ticks(ws_mode_e m);
    logic [PH_W-1:0] t;
    case (m)
      WS_NONE: t = PH_W'(2);
      WS_ONE:  t = PH_W'(4);
      default: t = PH_W'(6);
    endcase
    return t;
  endfunction

  // tail after the strobe rises, in half-clock phases
  function automatic logic [PH_W-1:0] hold_ticks(ws_mode_e m);
    logic [PH_W-1:0] t;
    if (m == WS_TWO_HOLD) t = PH_W'(4);
    else                  t = PH_W'(2);
    return t;
  endfunction

endpackage

// File: rtl/xmb_seq.sv
module xmb_seq
  import xmb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     start_wr,
  input  ws_mode_e start_mode,
  output logic     busy,
  output logic     last,
  output logic     is_wr,
  output logic     ale_win,
  output logic     addr_win,
  output logic     strobe_win,
  output logic     drive_win,
  output logic     cap_win
);

  logic            active_q, active_d;
  logic [PH_W-1:0] phase_q, phase_d;
  ws_mode_e        mode_q, mode_d;
  logic            wr_q, wr_d;
  logic            seq_en;
  logic [PH_W-1:0] strobe_end;
  logic [PH_W-1:0] last_ph;

  assign strobe_end = PH_STROBE_START + strobe_ticks(mode_q);
  assign last_ph    = strobe_end + hold_ticks(mode_q) - PH_ONE;

  assign busy  = active_q;
  assign is_wr = wr_q;
  assign last  = active_q && (phase_q == last_ph);

  // next-state
  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    mode_d   = mode_q;
    wr_d     = wr_q;
    if (start) begin
      active_d = 1'b1;
      phase_d  = '0;
      mode_d   = start_mode;
      wr_d     = start_wr;
    end else if (active_q) begin
      if (last) active_d = 1'b0;
      else      phase_d  = phase_q + PH_ONE;
    end
  end

  assign seq_en = start | active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      mode_q   <= WS_NONE;
      wr_q     <= 1'b0;
    end else if (seq_en) begin
      active_q <= active_d;
      phase_q  <= phase_d;
      mode_q   <= mode_d;
      wr_q     <= wr_d;
    end
  end

  // window decode
  always_comb begin
    ale_win    = active_q && (phase_q >= PH_ALE_FIRST) && (phase_q <= PH_ALE_LAST);
    addr_win   = active_q && ((phase_q < PH_ADDR_TAIL) ||
                              ((phase_q == PH_ADDR_TAIL) && !wr_q));
    strobe_win = active_q && (phase_q >= PH_STROBE_START) && (phase_q < strobe_end);
    drive_win  = addr_win || (active_q && wr_q);
    cap_win    = active_q && !wr_q && (phase_q == strobe_end - PH_ONE);
  end

  AST_ALE_OPENS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale_win) |=> ale_win); // R3
  AST_ALE_CLOSES_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_win && $past(ale_win)) |=> !ale_win); // R3

endmodule

// File: rtl/xmb_dp.sv
module xmb_dp #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          addr_win,
  input  logic          drive_win,
  input  logic          cap_win,
  input  logic [DW-1:0] bus_ad_in,
  output logic [AW-DW-1:0] ahi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [DW-1:0] rdata
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (cap_win) rdata_q <= bus_ad_in;
  end

  always_comb begin
    if (!drive_win)    ad_out = '0;
    else if (addr_win) ad_out = addr_q[DW-1:0];
    else               ad_out = wdata_q;
  end

  assign ad_oe = drive_win;
  assign ahi   = addr_q[AW-1:DW];
  assign rdata = rdata_q;

endmodule

// File: rtl/xmem_mux_ctrl.sv
module xmem_mux_ctrl
  import xmb_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_mode,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic             bus_ale,
  output logic             bus_rd_n,
  output logic             bus_wr_n,
  output logic [AW-DW-1:0] bus_ahi,
  output logic [DW-1:0]    bus_ad_out,
  output logic             bus_ad_oe,
  input  logic [DW-1:0]    bus_ad_in
);

  logic start, busy, last, is_wr;
  logic ale_win, addr_win, strobe_win, drive_win, cap_win;

  assign req_ready = !busy || last;
  assign start     = req_valid && req_ready;

  xmb_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_wr   (req_write),
    .start_mode (ws_mode_e'(req_mode)),
    .busy       (busy),
    .last       (last),
    .is_wr      (is_wr),
    .ale_win    (ale_win),
    .addr_win   (addr_win),
    .strobe_win (strobe_win),
    .drive_win  (drive_win),
    .cap_win    (cap_win)
  );

  xmb_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .addr_win  (addr_win),
    .drive_win (drive_win),
    .cap_win   (cap_win),
    .bus_ad_in (bus_ad_in),
    .ahi       (bus_ahi),
    .ad_out    (bus_ad_out),
    .ad_oe     (bus_ad_oe),
    .rdata     (rdata)
  );

  assign bus_ale  = ale_win;
  assign bus_rd_n = !(strobe_win && !is_wr);
  assign bus_wr_n = !(strobe_win && is_wr);
  assign done     = last;

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R11
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n)); // R11
  AST_RD_PORT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe); // R6
  AST_WR_PORT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_ad_oe); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_AHI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(bus_ahi)); // R9

endmodule

// File: tb/xmem_mux_ctrl_test.sv
module xmem_mux_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready, done;
  logic [1:0]  req_mode;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, rdata;
  logic        bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe;
  logic [7:0]  bus_ahi, bus_ad_out, bus_ad_in;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_mux_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mode(req_mode), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .bus_ale(bus_ale),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ahi(bus_ahi),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      report();
      $finish;
    end
  end

  task automatic check_idle();
    chk("R10 idle ale low", bus_ale, 0);
    chk("R10 idle port released", bus_ad_oe, 0);
    chk("R10 idle rd_n high", bus_rd_n, 1);
    chk("R10 idle wr_n high", bus_wr_n, 1);
    chk("R10 idle done low", done, 0);
    chk("R2 idle ready", req_ready, 1);
  endtask

  // one access; when chained the request is already on the inputs
  task automatic run(input logic [1:0] m, input bit wr, input logic [15:0] a,
                     input logic [7:0] wd, input logic [7:0] rsp, input bit chained);
    int s, h, l;
    bit strb;
    s = (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 3;
    h = (m == 2'd3) ? 2 : 1;
    l = 4 + 2*s + 2*h;
    if (!chained) begin
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_mode = m; req_addr = a; req_wdata = wd;
      chk("R2 ready before accept", req_ready, 1);
    end
    @(posedge clk);
    for (int p = 0; p < l; p++) begin
      @(negedge clk);
      if (p == 0) begin // R9: scramble inputs after acceptance
        req_valid = 1'b0; req_write = ~wr; req_mode = ~m; req_addr = ~a; req_wdata = ~wd;
      end
      bus_ad_in = (p == 3 + 2*s) ? rsp : ~rsp;
      strb = (p >= 4) && (p < 4 + 2*s);
      chk("R3 ale window", bus_ale, (p == 1 || p == 2));
      chk("R5 rd_n", bus_rd_n, !(strb && !wr));
      chk("R5 wr_n", bus_wr_n, !(strb && wr));
      if (wr) chk("R7 write drive", bus_ad_oe, 1);
      else    chk("R6 read drive", bus_ad_oe, (p <= 3));
      if (p < 3) chk("R3 low address", bus_ad_out, a[7:0]);
      else if (p == 3) chk("R4 cycle 3 port", bus_ad_out, wr ? wd : a[7:0]);
      else if (wr) chk("R7 write data", bus_ad_out, wd);
      chk("R9 high address", bus_ahi, a[15:8]);
      chk("R8 done", done, (p == l - 1));
      chk("R2 ready", req_ready, (p == l - 1));
      chk("R11 strobe overlap", (!bus_rd_n && !bus_wr_n) || (bus_ale && !(bus_rd_n && bus_wr_n)), 0);
      if (p == l - 1 && !wr) chk("R6 read data", rdata, rsp);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_mode = 2'd0;
    req_addr = '0; req_wdata = '0; bus_ad_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset ale", bus_ale, 0);
    chk("R1 reset rd_n", bus_rd_n, 1);
    chk("R1 reset wr_n", bus_wr_n, 1);
    chk("R1 reset port", bus_ad_oe, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset ready", req_ready, 1);
    rst_n = 1'b1;

    // sweep: every mode, both directions, several addresses
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 2; w++) begin
        for (int k = 0; k < 3; k++) begin
          logic [15:0] a;
          a = (k == 2) ? (16'hFFFF ^ 16'(m)) : 16'(k*16'h3A5D + m*16'h1111 + w*16'h0F0F);
          run(2'(m), bit'(w), a, 8'(a[15:8] + 8'h5A), 8'((a[7:0] ^ 8'hC3) + 8'(k)), 1'b0);
          @(negedge clk);
          check_idle();
          @(negedge clk);
          check_idle();
        end
      end
    end

    // back-to-back: next request raised in the final cycle
    for (int i = 0; i < 10; i++) begin
      logic [15:0] a;
      a = 16'(i*16'h1357 + 16'h0246);
      run(2'((i*3) % 4), bit'(i % 2), a, 8'(a[15:8] ^ 8'hA5), 8'(a[7:0] + 8'h11), i != 0);
      if (i < 9) begin
        logic [15:0] an;
        an = 16'((i+1)*16'h1357 + 16'h0246);
        req_valid = 1'b1; req_write = bit'((i+1) % 2); req_mode = 2'(((i+1)*3) % 4);
        req_addr = an; req_wdata = 8'(an[15:8] ^ 8'hA5);
      end else begin
        @(negedge clk);
        check_idle();
      end
    end

    report();
    $finish;
  end

endmodule